// File: doc/BRIEF.md
# I2C Register-Port Target with Pointer Auto-Increment

This block is an I2C target that gives a bus controller access to a small bank of eight-bit registers. It watches the open-drain SCL and SDA lines through synchroniser flops. It answers on a fixed 7-bit address and pulls SDA low through an enable output. The register contents are presented on a flat output bus so that the surrounding logic can use them.

A write transfer starts with a pointer byte. Bit 7 of that byte is the increment flag and bits 6:0 are the register index. Every further byte of the transfer is stored at the index the pointer holds. A read transfer carries no pointer byte. It starts at whatever index the pointer holds, which is the value left by the last write or the reset default. When the increment flag is set, the pointer steps by one after each byte in either direction. When the flag is clear, the pointer stays on the same register.

Top module: `i2c_regport`

## Requirements
- R1: The address byte 0x20 (7-bit address 0010000, R/W bit 0 = write) and the address byte 0x21 (R/W bit 1 = read) are acknowledged. Acknowledging means the target holds SDA low during the ninth clock of the byte.
- R2: After an address byte with any other 7-bit address, the target gives no ACK and leaves SDA released. Bytes that follow are ignored until the next START, so neither the registers nor the pointer change.
- R3: The first byte after an acknowledged write address is loaded into the pointer and acknowledged. Bit 7 of the pointer is the increment flag and bits 6:0 are the register index.
- R4: Each later byte of a write transfer is stored in the register that the pointer index selects, and each of these bytes is acknowledged.
- R5: With the increment flag set, the index advances by one after every data byte, so a burst fills successive registers.
- R6: With the increment flag clear, every data byte of a transfer goes to the same register, and a read repeats the same register.
- R7: A read sends the register at the current index, MSB first, with no pointer byte. The pointer keeps the value left by the last write, including any advances.
- R8: After reset the pointer holds 0x01, which is index 1 with the increment flag clear.
- R9: During a read, an ACK from the controller makes the target send another byte. That byte comes from the next register if the increment flag is set, and from the same register otherwise.
- R10: A NACK from the controller ends the read. The target releases SDA and stays silent until the next START.
- R11: The register bank has 16 registers. A read of index 16 or above returns 0x00. A write to index 16 or above is acknowledged and then discarded.
- R12: The target changes its SDA drive only while SCL is low.
- R13: After reset, SDA is released and register k holds the value k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which must run much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When high, SDA is pulled low |
| regs_o | output | 128 | Register bank contents; register k sits on bits 8k+7:8k |

## Verification
The bench reads straight after reset. This exposes a wrong default pointer, because every register resets to its own index and a wrong index returns a different value. A lost increment flag also shows, because the byte sent after an ACK would change.

Bursts cross the end of the bank, at index 15 and then 16. A design without the range check would either corrupt a register through index aliasing or return stale data instead of 0x00. Transfers to a foreign address are followed by a read that must still return the byte the old pointer selects. A design that listens after a mismatch would shift the pointer or overwrite a register.

After a NACK, the bench keeps clocking. A target that keeps driving SDA would return something other than all ones. A design that fails to advance the pointer on the last read byte would then restart the next read at the wrong register.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

   localparam int BYTE_W = 8;
   localparam int IDX_W  = 7;

   typedef enum logic [3:0] {
      S_IDLE,
      S_ADDR,
      S_ADDR_ACK,
      S_MAP_RX,
      S_MAP_ACK,
      S_WR_RX,
      S_WR_ACK,
      S_RD_TX,
      S_RD_ACK
   } tgt_state_e;

endpackage

// File: rtl/i2c_bus_sense.sv
module i2c_bus_sense #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("i2c_bus_sense: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
   logic                   scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
         scl_d  <= scl_s;
         sda_d  <= sda_s;
      end
   end

   assign scl_s     = scl_ff[SYNC_STAGES-1];
   assign sda_s     = sda_ff[SYNC_STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank #(
   parameter int NREG  = 16,
   parameter int IDX_W = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [7:0]           wr_data,
   input  logic [IDX_W-1:0]     rd_idx,
   output logic [7:0]           rd_data,
   output logic [NREG*8-1:0]    regs_o
);

   localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1;

   if (NREG < 1 || NREG > (1 << IDX_W) || NREG > 256) begin : g_bad_depth
      $error("i2c_regbank: NREG out of range for the index width");
   end

   logic [7:0] bank [NREG];

   for (genvar k = 0; k < NREG; k++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bank[k] <= 8'(k);
         else if (wr_en && wr_idx == IDX_W'(k))
            bank[k] <= wr_data;
      end
      assign regs_o[k*8 +: 8] = bank[k];
   end

   logic [SEL_W-1:0] rd_sel;
   assign rd_sel  = rd_idx[SEL_W-1:0];
   assign rd_data = (int'(rd_idx) < NREG) ? bank[rd_sel] : 8'h00;

   // R11: a write beyond the bank leaves every register untouched
   assert_oob_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_idx) >= NREG) |=> $stable(regs_o));

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
   import i2c_regport_pkg::*;
#(
   parameter logic [6:0] TGT_ADDR    = 7'h10,
   parameter int         NREG        = 16,
   parameter logic [7:0] MAP_RST     = 8'h01,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [NREG*8-1:0] regs_o
);

   localparam logic [3:0] BITS_DONE = 4'd8;

   if (NREG < 1 || NREG > (1 << IDX_W)) begin : g_bad_nreg
      $error("i2c_regport: NREG must lie in 1..128");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   i2c_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   tgt_state_e      state;
   logic [3:0]      bcnt;
   logic [7:0]      sh;
   logic [7:0]      map_q;
   logic            rw_q, mack_q, oe_q;
   logic            wr_en;
   logic [7:0]      rd_data;
   logic            rx_state, byte_in;

   assign rx_state = (state == S_ADDR) || (state == S_MAP_RX) || (state == S_WR_RX);
   assign byte_in  = scl_fall && (bcnt == BITS_DONE);
   assign wr_en    = (state == S_WR_RX) && byte_in && !start_det && !stop_det;

   i2c_regbank #(.NREG(NREG), .IDX_W(IDX_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (map_q[IDX_W-1:0]),
      .wr_data (sh),
      .rd_idx  (map_q[IDX_W-1:0]),
      .rd_data (rd_data),
      .regs_o  (regs_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         bcnt   <= '0;
         sh     <= '0;
         map_q  <= MAP_RST;
         rw_q   <= 1'b0;
         mack_q <= 1'b0;
         oe_q   <= 1'b0;
      end else if (start_det) begin
         state <= S_ADDR;
         bcnt  <= '0;
         oe_q  <= 1'b0;
      end else if (stop_det) begin
         state <= S_IDLE;
         oe_q  <= 1'b0;
      end else if (rx_state) begin
         if (scl_rise && bcnt != BITS_DONE) begin
            sh   <= {sh[6:0], sda_s};
            bcnt <= bcnt + 4'd1;
         end else if (byte_in) begin
            bcnt <= '0;
            if (state == S_ADDR) begin
               if (sh[7:1] == TGT_ADDR) begin
                  rw_q  <= sh[0];
                  oe_q  <= 1'b1;
                  state <= S_ADDR_ACK;
               end else begin
                  state <= S_IDLE;
               end
            end else if (state == S_MAP_RX) begin
               map_q <= sh;
               oe_q  <= 1'b1;
               state <= S_MAP_ACK;
            end else begin
               if (map_q[7]) map_q[6:0] <= map_q[6:0] + 7'd1;
               oe_q  <= 1'b1;
               state <= S_WR_ACK;
            end
         end
      end else begin
         unique case (state)
            S_ADDR_ACK: if (scl_fall) begin
               if (rw_q) begin
                  sh    <= {rd_data[6:0], 1'b0};
                  oe_q  <= ~rd_data[7];
                  bcnt  <= 4'd1;
                  state <= S_RD_TX;
               end else begin
                  oe_q  <= 1'b0;
                  state <= S_MAP_RX;
               end
            end
            S_MAP_ACK, S_WR_ACK: if (scl_fall) begin
               oe_q  <= 1'b0;
               state <= S_WR_RX;
            end
            S_RD_TX: if (scl_fall) begin
               if (bcnt == BITS_DONE) begin
                  oe_q  <= 1'b0;
                  state <= S_RD_ACK;
                  if (map_q[7]) map_q[6:0] <= map_q[6:0] + 7'd1;
               end else begin
                  oe_q <= ~sh[7];
                  sh   <= {sh[6:0], 1'b0};
                  bcnt <= bcnt + 4'd1;
               end
            end
            S_RD_ACK: begin
               if (scl_rise) mack_q <= ~sda_s;
               if (scl_fall) begin
                  if (mack_q) begin
                     sh    <= {rd_data[6:0], 1'b0};
                     oe_q  <= ~rd_data[7];
                     bcnt  <= 4'd1;
                     state <= S_RD_TX;
                  end else begin
                     state <= S_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe = oe_q;

   // R12: the drive on SDA moves only while the synchronised SCL is low
   assert_sda_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(oe_q) |-> !scl_s);

   // R5 and R6: a stored byte steps the index only when the flag is set
   assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (map_q[6:0] == ($past(map_q[7]) ? $past(map_q[6:0]) + 7'd1
                                                : $past(map_q[6:0]))));

   // R10: a NACK from the controller leaves the target idle with SDA released
   assert_nack_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_RD_ACK && scl_fall && !mack_q && !start_det && !stop_det)
         |=> (state == S_IDLE && !sda_oe));

   // R2: while idle (also after an address mismatch) SDA is never pulled
   assert_foreign_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE) |-> !sda_oe);

endmodule

// File: tb/test_i2c_regport.sv
module test_i2c_regport;

   localparam int NREG = 16;
   localparam int Q    = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              scl_drv = 1'b1;
   logic              sda_low = 1'b0;
   logic              sda_line;
   logic              sda_oe;
   logic [NREG*8-1:0] regs_o;

   int  n_chk = 0;
   int  n_bad = 0;
   int  r12_viol = 0;
   bit  done = 1'b0;
   logic [7:0] mdl [NREG];

   always #10 clk = ~clk;

   assign sda_line = !(sda_low || sda_oe);

   i2c_regport i_i2c_regport (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_i  (scl_drv),
      .sda_i  (sda_line),
      .sda_oe (sda_oe),
      .regs_o (regs_o)
   );

   logic prev_oe = 1'b0;
   always @(negedge clk) begin
      if (rst_n && sda_oe !== prev_oe && scl_drv) r12_viol++;
      prev_oe = sda_oe;
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_regs(input string req);
      for (int k = 0; k < NREG; k++)
         check(req, $sformatf("reg%0d", k), int'(regs_o[k*8 +: 8]), int'(mdl[k]));
   endtask

   task automatic wait_q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bit_cycle(input logic b, output logic r);
      sda_low = !b;
      wait_q();
      scl_drv = 1'b1;
      wait_q();
      r = sda_line;
      wait_q();
      scl_drv = 1'b0;
      wait_q();
   endtask

   task automatic bus_start();
      sda_low = 1'b0;
      wait_q();
      scl_drv = 1'b1;
      wait_q();
      sda_low = 1'b1;
      wait_q();
      scl_drv = 1'b0;
      wait_q();
   endtask

   task automatic bus_stop();
      sda_low = 1'b1;
      wait_q();
      scl_drv = 1'b1;
      wait_q();
      sda_low = 1'b0;
      wait_q();
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) bit_cycle(d[i], r);
      bit_cycle(1'b1, r);
      ack = !r;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         bit_cycle(1'b1, r);
         d[i] = r;
      end
      bit_cycle(!give_ack, r);
   endtask

   task automatic wr_hdr(input logic [7:0] mapv);
      logic ack;
      bus_start();
      send_byte(8'h20, ack);
      check("R1", "write address ACK", int'(ack), 1);
      send_byte(mapv, ack);
      check("R3", "pointer byte ACK", int'(ack), 1);
   endtask

   task automatic rd_hdr();
      logic ack;
      bus_start();
      send_byte(8'h21, ack);
      check("R1", "read address ACK", int'(ack), 1);
   endtask

   task automatic wr_data(input logic [7:0] d, input string req);
      logic ack;
      send_byte(d, ack);
      check(req, "data byte ACK", int'(ack), 1);
   endtask

   task automatic rd_expect(input logic give_ack, input logic [7:0] exp, input string req);
      logic [7:0] d;
      recv_byte(give_ack, d);
      check(req, "read byte", int'(d), int'(exp));
   endtask

   // R13: reset state
   task automatic t_reset();
      check("R13", "sda released", int'(sda_oe), 0);
      check_regs("R13");
   endtask

   // R8, R7, R6, R9: first read uses the default pointer, flag clear
   task automatic t_default_read();
      rd_hdr();
      rd_expect(1'b1, 8'h01, "R8");
      rd_expect(1'b0, 8'h01, "R9");
      bus_stop();
   endtask

   // R3, R4, R5, R7: burst write, then read continues from the advanced pointer
   task automatic t_burst();
      wr_hdr(8'h83);
      wr_data(8'hA1, "R4");
      wr_data(8'hB2, "R4");
      wr_data(8'hC3, "R5");
      bus_stop();
      mdl[3] = 8'hA1; mdl[4] = 8'hB2; mdl[5] = 8'hC3;
      check_regs("R5");
      rd_hdr();
      rd_expect(1'b1, 8'h06, "R7");
      rd_expect(1'b1, 8'h07, "R9");
      rd_expect(1'b0, 8'h08, "R9");
      bus_stop();
   endtask

   // R7, R9: pointer set then repeated START into a read
   task automatic t_ptr_read();
      wr_hdr(8'h83);
      rd_hdr();
      rd_expect(1'b1, 8'hA1, "R7");
      rd_expect(1'b1, 8'hB2, "R9");
      rd_expect(1'b0, 8'hC3, "R9");
      bus_stop();
   endtask

   // R6: flag clear keeps hitting one register
   task automatic t_no_incr();
      wr_hdr(8'h0A);
      wr_data(8'h11, "R6");
      wr_data(8'h22, "R6");
      wr_data(8'h33, "R6");
      bus_stop();
      mdl[10] = 8'h33;
      check_regs("R6");
      rd_hdr();
      rd_expect(1'b1, 8'h33, "R6");
      rd_expect(1'b0, 8'h33, "R6");
      bus_stop();
   endtask

   // R2: foreign addresses are ignored, pointer and registers untouched
   task automatic t_foreign();
      logic ack;
      logic [7:0] d;
      bus_start();
      send_byte(8'h42, ack);
      check("R2", "foreign write address no ACK", int'(ack), 0);
      send_byte(8'h85, ack);
      check("R2", "ignored byte no ACK", int'(ack), 0);
      send_byte(8'h77, ack);
      check("R2", "ignored byte no ACK", int'(ack), 0);
      bus_stop();
      bus_start();
      send_byte(8'h23, ack);
      check("R2", "foreign read address no ACK", int'(ack), 0);
      recv_byte(1'b0, d);
      check("R2", "bus left released", int'(d), 8'hFF);
      bus_stop();
      check_regs("R2");
      rd_hdr();
      rd_expect(1'b0, 8'h33, "R2");
      bus_stop();
   endtask

   // R11: burst runs off the end of the bank
   task automatic t_out_of_range();
      wr_hdr(8'h8E);
      wr_data(8'hE1, "R11");
      wr_data(8'hF2, "R11");
      wr_data(8'h93, "R11");
      bus_stop();
      mdl[14] = 8'hE1; mdl[15] = 8'hF2;
      check_regs("R11");
      wr_hdr(8'h8F);
      rd_hdr();
      rd_expect(1'b1, 8'hF2, "R11");
      rd_expect(1'b1, 8'h00, "R11");
      rd_expect(1'b0, 8'h00, "R11");
      bus_stop();
   endtask

   // R10: NACK ends the read, SDA stays released, next read resumes
   task automatic t_nack();
      logic [7:0] d;
      wr_hdr(8'h83);
      rd_hdr();
      rd_expect(1'b0, 8'hA1, "R10");
      recv_byte(1'b0, d);
      check("R10", "no drive after NACK", int'(d), 8'hFF);
      check("R10", "sda_oe low after NACK", int'(sda_oe), 0);
      bus_stop();
      rd_hdr();
      rd_expect(1'b0, 8'hB2, "R10");
      bus_stop();
   endtask

   initial begin
      for (int k = 0; k < NREG; k++) mdl[k] = 8'(k);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_default_read();
      t_burst();
      t_ptr_read();
      t_no_incr();
      t_foreign();
      t_out_of_range();
      t_nack();
      check("R12", "SDA drive changes with SCL high", r12_viol, 0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule